// File: doc/BRIEF.md
# Banked Edge/Level Interrupt Controller

This block collects up to four banks of 32 active-high request lines and turns them into two CPU request outputs: a normal-class request and a fast-class request. Every line carries its own configuration word that picks its priority, whether it is sensed on a new assertion (edge) or while held (level), and which of the two outputs it feeds. Pending state is latched per line. A per-bank mask register decides which pending lines may take part in arbitration.

Each CPU output behaves as a one-shot. It rises when it is armed and some unmasked pending line of its class exists. At that moment it disarms and captures the number of the winning line into a code register. Software reads the code register to find the source. On an edge-sensed line that read also acknowledges the line. Software then writes the control register to drop the output and re-arm it, and the output is re-evaluated in that same cycle. A software-set register lets firmware inject an interrupt on any line.

Registers are reached over a plain 32-bit bus with address, write enable, read enable and data. Read data is combinational from the address. Side effects of a read (the acknowledge) and of a write take effect at the next rising clock edge.

Top module: `intc_banked`

## Requirements
- R1: After reset, every mask register reads 0xFFFFFFFF and all pending bits read 0. All configuration words read 0 and both code registers read 0. Both CPU outputs are low and both are armed.
- R2: Address bits [9:8] select the bank and bits [7:0] select the register within it: 0x00 pending, 0x04 mask, 0x10 normal code, 0x14 fast code, 0x18 control, 0x1C+4*n configuration of line n, 0x9C software set. A configuration word stores priority in bits [6:2], sense in bit 1 (0 = edge, 1 = level) and class in bit 0 (1 = fast). It reads back with all higher bits zero.
- R3: An edge-sensed line becomes pending in the clock edge after its request goes from 0 to 1. It stays pending after the request drops. A request that is held high does not set the line again.
- R4: A level-sensed line is pending in every cycle that follows a cycle with its request high. It clears at the edge where its request goes from 1 to 0.
- R5: Writing the pending register ANDs the pending bits with the written value. A level-sensed line whose request is high stays pending regardless of the written value.
- R6: Masked lines (mask bit 1) never raise an output. After a mask write, the outputs reflect the new mask one clock edge after the write edge.
- R7: Lines with class bit 1 raise only the fast output. Lines with class bit 0 raise only the normal output.
- R8: The winner is the candidate with the smallest priority value. Among equal priorities, the candidate with the highest global line number (32*bank + line) wins.
- R9: When an armed output rises it disarms and latches the winning global line number. While disarmed, new candidates change neither the output nor its code.
- R10: Writing control bit 0 (normal) or bit 1 (fast) in bank 0 re-evaluates that output at the write edge. It goes high with a freshly latched code if a candidate exists, and otherwise it goes low and re-arms.
- R11: Reading a code register in bank 0 returns the latched line number. If that line is edge-sensed its pending bit clears at the read edge, unless a new assertion of the same line occurs in that same cycle. Level lines are not cleared. Code addresses in other banks read 0.
- R12: A write to a bank's software-set register makes only the lowest set bit of the written value pending. A write of 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 10 | Register byte address |
| bus_wen | input | 1 | Write strobe |
| bus_ren | input | 1 | Read strobe (needed for the acknowledge on code reads) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq_req | input | 128 | Request lines, active high, global index 32*bank + line |
| cpu_norm_o | output | 1 | Normal-class CPU request |
| cpu_fast_o | output | 1 | Fast-class CPU request |

## Verification
An acknowledge caused by a code read and a fresh rising request on the very same edge-sensed line can land on one clock edge. One action clears the pending bit and the other sets it. The bench provokes this by raising the request of the line that currently owns the normal code in the cycle it reads that code. It then reads the pending register and expects the bit still set, because the new assertion must not be lost. A second code read with no new assertion then confirms that the bit clears.

// File: rtl/intc_pkg.sv
`timescale 1ns/1ps
package intc_pkg;
  localparam int LINES  = 32;
  localparam int LIDX_W = 5;
  localparam int PRIO_W = 5;

  localparam logic [7:0] OFS_PEND     = 8'h00;
  localparam logic [7:0] OFS_MASK     = 8'h04;
  localparam logic [7:0] OFS_CODE_N   = 8'h10;
  localparam logic [7:0] OFS_CODE_F   = 8'h14;
  localparam logic [7:0] OFS_CTRL     = 8'h18;
  localparam logic [7:0] OFS_CFG_LO   = 8'h1C;
  localparam logic [7:0] OFS_CFG_HI   = 8'h98;
  localparam logic [7:0] OFS_SOFT     = 8'h9C;

  typedef enum logic [2:0] {
    RK_NONE, RK_PEND, RK_MASK, RK_CODE_N, RK_CODE_F, RK_CTRL, RK_CFG, RK_SOFT
  } reg_kind_e;
endpackage

// File: rtl/intc_regdec.sv
`timescale 1ns/1ps
module intc_regdec
  import intc_pkg::*;
#(
  parameter int NBANK  = 4,
  parameter int BANK_W = 2,
  parameter int ADDR_W = 10
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_kind_e         kind_o,
  output logic [BANK_W-1:0] bank_o,
  output logic [LIDX_W-1:0] line_o
);
  logic [7:0] off;
  logic [7:0] cfg_delta;
  logic       bank_ok;
  logic       bank0;

  always_comb begin
    off       = addr_i[7:0];
    bank_o    = addr_i[ADDR_W-1:8];
    bank_ok   = (32'(bank_o) < 32'(NBANK));
    bank0     = (bank_o == '0);
    cfg_delta = off - OFS_CFG_LO;
    line_o    = cfg_delta[LIDX_W+1:2];
    kind_o    = RK_NONE;
    if (bank_ok) begin
      if (off == OFS_PEND)                          kind_o = RK_PEND;
      else if (off == OFS_MASK)                     kind_o = RK_MASK;
      else if (off == OFS_CODE_N && bank0)          kind_o = RK_CODE_N;
      else if (off == OFS_CODE_F && bank0)          kind_o = RK_CODE_F;
      else if (off == OFS_CTRL && bank0)            kind_o = RK_CTRL;
      else if (off == OFS_SOFT)                     kind_o = RK_SOFT;
      else if (off >= OFS_CFG_LO && off <= OFS_CFG_HI && off[1:0] == 2'b00)
        kind_o = RK_CFG;
    end
  end
endmodule

// File: rtl/intc_bank.sv
`timescale 1ns/1ps
module intc_bank
  import intc_pkg::*;
#(
  parameter int NL     = LINES,
  parameter int PW     = PRIO_W,
  parameter int LW     = LIDX_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NL-1:0]   req_i,
  input  logic            wr_pend_i,
  input  logic            wr_mask_i,
  input  logic            wr_cfg_i,
  input  logic            wr_soft_i,
  input  logic [LW-1:0]   cfg_line_i,
  input  logic [31:0]     wdata_i,
  input  logic            ack_i,
  input  logic [LW-1:0]   ack_line_i,
  output logic [NL-1:0]   pend_o,
  output logic [NL-1:0]   mask_o,
  output logic [NL-1:0]   sense_o,
  output logic [NL-1:0]   fast_o,
  output logic [NL*PW-1:0] prio_o
);
  logic [NL-1:0] req_q, pend_q, pend_d, mask_q, sense_q, fast_q;
  logic [NL-1:0][PW-1:0] prio_q;
  logic [NL-1:0] wd, soft_vec, edge_set, lvl_set, lvl_clr, keep;

  always_comb begin
    wd       = wdata_i[NL-1:0];
    soft_vec = wr_soft_i ? (wd & (~wd + 1'b1)) : '0;
    edge_set = req_i & ~req_q & ~sense_q;
    lvl_set  = req_i & sense_q;
    lvl_clr  = sense_q & req_q & ~req_i;
    keep     = pend_q & ~lvl_clr;
    if (wr_pend_i) keep = keep & (wd | (req_i & sense_q));
    if (ack_i && !sense_q[ack_line_i]) keep[ack_line_i] = 1'b0;
    pend_d   = keep | edge_set | lvl_set | soft_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= '0;
      pend_q  <= '0;
      mask_q  <= '1;
      sense_q <= '0;
      fast_q  <= '0;
      prio_q  <= '0;
    end else begin
      req_q  <= req_i;
      pend_q <= pend_d;
      if (wr_mask_i) mask_q <= wd;
      if (wr_cfg_i) begin
        prio_q[cfg_line_i]  <= wdata_i[PW+1:2];
        sense_q[cfg_line_i] <= wdata_i[1];
        fast_q[cfg_line_i]  <= wdata_i[0];
      end
    end
  end

  assign pend_o  = pend_q;
  assign mask_o  = mask_q;
  assign sense_o = sense_q;
  assign fast_o  = fast_q;
  assign prio_o  = prio_q;

  AST_EDGE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (|(req_i & ~req_q & ~sense_q)) |=> (($past(req_i & ~req_q & ~sense_q) & ~pend_q) == '0)); // R3
  AST_LEVEL_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (|(req_i & sense_q)) |=> (($past(req_i & sense_q) & ~pend_q) == '0)); // R4
  AST_LEVEL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (|(sense_q & req_q & ~req_i & ~soft_vec)) |=>
      ((pend_q & $past(sense_q & req_q & ~req_i & ~soft_vec)) == '0)); // R4
  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mask_i |=> (mask_q == $past(wd))); // R6
endmodule

// File: rtl/intc_resolver.sv
`timescale 1ns/1ps
module intc_resolver #(
  parameter int NLINE = 128,
  parameter int PW    = 5,
  parameter int IW    = 7
) (
  input  logic [NLINE-1:0]    cand_i,
  input  logic [NLINE*PW-1:0] prio_i,
  output logic                any_o,
  output logic [IW-1:0]       win_o
);
  logic [PW-1:0] best;

  always_comb begin
    best  = '1;
    win_o = '0;
    any_o = 1'b0;
    for (int g = 0; g < NLINE; g++) begin
      if (cand_i[g] && (!any_o || prio_i[g*PW +: PW] <= best)) begin
        best  = prio_i[g*PW +: PW];
        win_o = IW'(g);
        any_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/intc_outctl.sv
`timescale 1ns/1ps
module intc_outctl #(
  parameter int IW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rearm_i,
  input  logic          any_i,
  input  logic [IW-1:0] win_i,
  output logic          req_o,
  output logic [IW-1:0] code_o
);
  logic          out_q, out_d, arm_q, arm_d;
  logic [IW-1:0] code_q, code_d;
  logic          code_en;

  always_comb begin
    out_d  = out_q;
    arm_d  = arm_q;
    code_d = code_q;
    if (rearm_i || arm_q) begin
      if (any_i) begin
        out_d  = 1'b1;
        arm_d  = 1'b0;
        code_d = win_i;
      end else if (rearm_i) begin
        out_d = 1'b0;
        arm_d = 1'b1;
      end
    end
    code_en = (code_d != code_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= 1'b0;
      arm_q  <= 1'b1;
      code_q <= '0;
    end else begin
      out_q <= out_d;
      arm_q <= arm_d;
      if (code_en) code_q <= code_d;
    end
  end

  assign req_o  = out_q;
  assign code_o = code_q;

  AST_OUT_EXCLUDES_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_q && arm_q)); // R9
  AST_RISE_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(out_q) && !$past(rearm_i)) |-> $past(arm_q)); // R9
  AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rearm_i && !arm_q) |=> $stable(code_q)); // R9
  AST_REARM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rearm_i && !any_i) |=> (!out_q && arm_q)); // R10
endmodule

// File: rtl/intc_banked.sv
`timescale 1ns/1ps
module intc_banked
  import intc_pkg::*;
#(
  parameter int NBANK  = 4,
  parameter int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1,
  parameter int ADDR_W = 8 + BANK_W,
  parameter int NLINE  = NBANK * LINES,
  parameter int IDX_W  = LIDX_W + BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wen,
  input  logic              bus_ren,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NLINE-1:0]  irq_req,
  output logic              cpu_norm_o,
  output logic              cpu_fast_o
);
  localparam int NCLS = 2;

  reg_kind_e           kind;
  logic [BANK_W-1:0]   sel_bank;
  logic [LIDX_W-1:0]   cfg_line;
  logic [NLINE-1:0]    all_pend, all_mask, all_sense, all_fast;
  logic [NLINE*PRIO_W-1:0] all_prio;
  logic [NCLS-1:0][NLINE-1:0] cand;
  logic [NCLS-1:0]     rearm, any, outv;
  logic [NCLS-1:0][IDX_W-1:0] win, code;
  logic                ack_valid;
  logic [IDX_W-1:0]    ack_line;
  logic [IDX_W-1:0]    cfg_gline;

  intc_regdec #(.NBANK(NBANK), .BANK_W(BANK_W), .ADDR_W(ADDR_W)) u_dec (
    .addr_i(bus_addr), .kind_o(kind), .bank_o(sel_bank), .line_o(cfg_line)
  );

  assign ack_valid = bus_ren && (kind == RK_CODE_N || kind == RK_CODE_F);
  assign ack_line  = (kind == RK_CODE_F) ? code[1] : code[0];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    localparam logic [BANK_W-1:0] BIDX = BANK_W'(b);
    logic wr_here;
    assign wr_here = bus_wen && (sel_bank == BIDX);
    intc_bank u_bank (
      .clk(clk), .rst_n(rst_n),
      .req_i(irq_req[b*LINES +: LINES]),
      .wr_pend_i(wr_here && kind == RK_PEND),
      .wr_mask_i(wr_here && kind == RK_MASK),
      .wr_cfg_i(wr_here && kind == RK_CFG),
      .wr_soft_i(wr_here && kind == RK_SOFT),
      .cfg_line_i(cfg_line),
      .wdata_i(bus_wdata),
      .ack_i(ack_valid && ack_line[IDX_W-1:LIDX_W] == BIDX),
      .ack_line_i(ack_line[LIDX_W-1:0]),
      .pend_o(all_pend[b*LINES +: LINES]),
      .mask_o(all_mask[b*LINES +: LINES]),
      .sense_o(all_sense[b*LINES +: LINES]),
      .fast_o(all_fast[b*LINES +: LINES]),
      .prio_o(all_prio[b*LINES*PRIO_W +: LINES*PRIO_W])
    );
  end

  assign cand[0] = all_pend & ~all_mask & ~all_fast;
  assign cand[1] = all_pend & ~all_mask & all_fast;
  assign rearm[0] = bus_wen && kind == RK_CTRL && bus_wdata[0];
  assign rearm[1] = bus_wen && kind == RK_CTRL && bus_wdata[1];

  for (genvar c = 0; c < NCLS; c++) begin : g_cls
    intc_resolver #(.NLINE(NLINE), .PW(PRIO_W), .IW(IDX_W)) u_res (
      .cand_i(cand[c]), .prio_i(all_prio), .any_o(any[c]), .win_o(win[c])
    );
    intc_outctl #(.IW(IDX_W)) u_out (
      .clk(clk), .rst_n(rst_n), .rearm_i(rearm[c]), .any_i(any[c]),
      .win_i(win[c]), .req_o(outv[c]), .code_o(code[c])
    );
  end

  assign cpu_norm_o = outv[0];
  assign cpu_fast_o = outv[1];
  assign cfg_gline  = {sel_bank, cfg_line};

  always_comb begin
    bus_rdata = '0;
    case (kind)
      RK_PEND:   bus_rdata = all_pend[sel_bank*LINES +: LINES];
      RK_MASK:   bus_rdata = all_mask[sel_bank*LINES +: LINES];
      RK_CODE_N: bus_rdata = {{(32-IDX_W){1'b0}}, code[0]};
      RK_CODE_F: bus_rdata = {{(32-IDX_W){1'b0}}, code[1]};
      RK_CFG:    bus_rdata = {{(30-PRIO_W){1'b0}}, all_prio[cfg_gline*PRIO_W +: PRIO_W],
                              all_sense[cfg_gline], all_fast[cfg_gline]};
      default:   bus_rdata = '0;
    endcase
  end

  AST_ACK_OWN_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_fast_o) |-> all_fast[code[1]]); // R7
endmodule

// File: tb/tb_intc_banked.sv
`timescale 1ns/1ps
module tb_intc_banked;
  logic         clk, rst_n, wen, ren;
  logic [9:0]   addr;
  logic [31:0]  wdata, rdata;
  logic [127:0] req;
  logic         norm, fast;
  int checks = 0, errors = 0;
  bit done = 0;

  intc_banked dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wen(wen), .bus_ren(ren),
    .bus_wdata(wdata), .bus_rdata(rdata), .irq_req(req),
    .cpu_norm_o(norm), .cpu_fast_o(fast)
  );

  initial begin clk = 1'b0; forever #4 clk = ~clk; end

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    addr = a; wdata = d; wen = 1'b1;
    @(negedge clk);
    wen = 1'b0;
  endtask

  task automatic rd_chk(input string rq, input logic [9:0] a, input logic [31:0] exp);
    addr = a; ren = 1'b1;
    #1 check(rq, rdata, exp);
    @(negedge clk);
    ren = 1'b0;
  endtask

  function automatic logic [9:0] cfg_a(input int b, input int n);
    return 10'(b * 256 + 28 + 4 * n);
  endfunction

  task automatic t_reset;
    check("R1 norm low", {31'b0, norm}, 0);
    check("R1 fast low", {31'b0, fast}, 0);
    rd_chk("R1 mask bank0", 10'h004, 32'hFFFF_FFFF);
    rd_chk("R1 mask bank3", 10'h304, 32'hFFFF_FFFF);
    rd_chk("R1 pending", 10'h100, 0);
    rd_chk("R1 cfg", cfg_a(2, 5), 0);
    rd_chk("R1 code", 10'h014, 0);
  endtask

  task automatic t_cfg;
    wr(cfg_a(1, 7), 32'hFFFF_FFFF);
    rd_chk("R2 cfg readback", cfg_a(1, 7), 32'h7F);
    rd_chk("R2 other bank untouched", cfg_a(0, 7), 0);
    wr(cfg_a(1, 7), 32'h0);
    rd_chk("R2 code in bank1 reads 0", 10'h110, 0);
  endtask

  task automatic t_edge;
    req[3] = 1'b1; tick(1);
    rd_chk("R3 edge set", 10'h000, 32'h8);
    wr(10'h000, 0);
    rd_chk("R3 held request no reset", 10'h000, 0);
    req[3] = 1'b0; tick(1); req[3] = 1'b1; tick(1);
    rd_chk("R3 new assertion", 10'h000, 32'h8);
    req[3] = 1'b0; tick(2);
    rd_chk("R3 stays after drop", 10'h000, 32'h8);
    wr(10'h000, 0);
  endtask

  task automatic t_level;
    wr(cfg_a(0, 4), 32'h2);
    req[4] = 1'b1; req[3] = 1'b1; tick(1);
    rd_chk("R4 level set", 10'h000, 32'h18);
    wr(10'h000, 0);
    rd_chk("R5 level immune, edge cleared", 10'h000, 32'h10);
    req[4] = 1'b0; req[3] = 1'b0; tick(1);
    rd_chk("R4 level clears on drop", 10'h000, 0);
  endtask

  task automatic t_prio;
    wr(cfg_a(0, 2), 32'h14);
    wr(cfg_a(2, 9), 32'h14);
    wr(cfg_a(1, 0), 32'h24);
    req[2] = 1'b1; req[32] = 1'b1; req[73] = 1'b1; tick(1);
    req[2] = 1'b0; req[32] = 1'b0; req[73] = 1'b0; tick(2);
    check("R6 masked stays low", {31'b0, norm}, 0);
    wr(10'h104, 32'hFFFF_FFFE);
    check("R6 not yet at write edge", {31'b0, norm}, 0);
    tick(1);
    check("R6 raised cycle after mask", {31'b0, norm}, 1);
    check("R7 fast unaffected", {31'b0, fast}, 0);
    rd_chk("R9 code latched", 10'h010, 32);
    wr(10'h004, 32'hFFFF_FFFB);
    wr(10'h204, 32'hFFFF_FDFF);
    tick(1);
    rd_chk("R9 code held while disarmed", 10'h010, 32);
    wr(10'h018, 32'h1);
    check("R10 rearm raises at once", {31'b0, norm}, 1);
    rd_chk("R8 tie highest index", 10'h010, 73);
    req[32] = 1'b1; tick(1); req[32] = 1'b0;
    wr(10'h018, 32'h1);
    rd_chk("R8 lower value wins", 10'h010, 2);
    wr(10'h018, 32'h1);
    rd_chk("R8 last candidate", 10'h010, 32);
    wr(10'h018, 32'h1);
    check("R10 idle rearm drops", {31'b0, norm}, 0);
    rd_chk("R11 ack cleared bank2", 10'h200, 0);
    wr(10'h004, 32'hFFFF_FFFF);
    wr(10'h104, 32'hFFFF_FFFF);
    wr(10'h204, 32'hFFFF_FFFF);
  endtask

  task automatic t_fast;
    wr(cfg_a(3, 1), 32'h1);
    wr(10'h304, 32'hFFFF_FFFD);
    req[97] = 1'b1; tick(1); req[97] = 1'b0; tick(1);
    check("R7 fast raised", {31'b0, fast}, 1);
    check("R7 normal quiet", {31'b0, norm}, 0);
    rd_chk("R7 fast code", 10'h014, 97);
    rd_chk("R11 edge acked", 10'h300, 0);
    wr(10'h018, 32'h2);
    check("R10 fast dropped", {31'b0, fast}, 0);
    wr(10'h304, 32'hFFFF_FFFF);
  endtask

  task automatic t_level_ack;
    wr(10'h004, 32'hFFFF_FFEF);
    req[4] = 1'b1; tick(2);
    check("R4 level raises normal", {31'b0, norm}, 1);
    rd_chk("R11 code level line", 10'h010, 4);
    rd_chk("R11 level not acked", 10'h000, 32'h10);
    rd_chk("R11 code in bank2 reads 0", 10'h210, 0);
    req[4] = 1'b0; tick(1);
    rd_chk("R4 cleared after drop", 10'h000, 0);
    wr(10'h018, 32'h1);
    check("R10 normal dropped", {31'b0, norm}, 0);
    wr(10'h004, 32'hFFFF_FFFF);
  endtask

  task automatic t_soft;
    wr(10'h29C, 32'h30);
    rd_chk("R12 lowest bit only", 10'h200, 32'h10);
    check("R12 masked no output", {31'b0, norm}, 0);
    wr(10'h200, 0);
    wr(10'h29C, 0);
    rd_chk("R12 zero write no effect", 10'h200, 0);
  endtask

  task automatic t_same_cycle;
    wr(cfg_a(0, 6), 32'h0);
    wr(10'h004, 32'hFFFF_FFBF);
    req[6] = 1'b1; tick(2); req[6] = 1'b0;
    check("R9 raised for line6", {31'b0, norm}, 1);
    tick(1);
    req[6] = 1'b1;
    rd_chk("R11 code with new edge", 10'h010, 6);
    rd_chk("R11 new edge beats ack", 10'h000, 32'h40);
    req[6] = 1'b0;
    rd_chk("R11 plain ack code", 10'h010, 6);
    rd_chk("R11 plain ack clears", 10'h000, 0);
    wr(10'h018, 32'h1);
    wr(10'h004, 32'hFFFF_FFFF);
  endtask

  initial begin
    rst_n = 1'b1; wen = 1'b0; ren = 1'b0; addr = '0; wdata = '0; req = '0;
    #1 rst_n = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_cfg();
    t_edge();
    t_level();
    t_prio();
    t_fast();
    t_level_ack();
    t_soft();
    t_same_cycle();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule